// File: doc/BRIEF.md
# Logical Clock Relation Checker

This block watches two single-bit event streams on a common system clock. Call them the reference stream `ref_ev_i` and the derived stream `der_ev_i`. A stream has an event in a cycle when its value is 1 at the rising edge. Signal transitions do not count as events. The block checks whether the derived stream keeps one of two ordinal relations to the reference stream, counted from a threshold `THRESH` that defaults to 5. The input `rel_mode_i` selects the relation.

- **Mirror relation:** the derived stream stays silent until the `THRESH`-th reference event. From that event onwards it copies the reference stream exactly.
- **One-shot relation:** the derived stream fires only on the `THRESH`-th reference event. After that it stays silent forever.

The block counts reference events in an ordinal counter. The counter has no timeout, so events may arrive back to back or thousands of cycles apart. Each cycle, a classifier compares the sampled pair against the current phase. Any breach of the relation produces a registered one-cycle violation pulse and sets a sticky error flag. The running event count and the phase are also visible at the ports. A synchronous reset marks the start of observation.

Top module: `evrel_monitor`

## Requirements
- R1: `ev_count_o` rises by exactly one after each sampled cycle with `ref_ev_i`=1 until it equals `THRESH`, then holds there. It never changes on idle cycles, however long the gap between events.
- R2: A sample with `der_ev_i`=1 and `ref_ev_i`=0 is a violation in every phase and under both relations.
- R3: While fewer than `THRESH`-1 reference events have been counted, any sample with `der_ev_i`=1 is a violation.
- R4: On the sample that carries the `THRESH`-th reference event, `der_ev_i`=0 is a violation and `der_ev_i`=1 is correct. The count reaches `THRESH` either way.
- R5: With `rel_mode_i`=0 (mirror), after the `THRESH`-th event any sample where `der_ev_i` differs from `ref_ev_i` is a violation.
- R6: With `rel_mode_i`=1 (one-shot), after the `THRESH`-th event any sample with `der_ev_i`=1 is a violation. A sample with `der_ev_i`=0 is never a violation, whatever `ref_ev_i` is.
- R7: `viol_o` is 1 in the cycle right after a violating sample edge, and 0 after every non-violating sample edge.
- R8: `err_o` goes to 1 together with the first `viol_o` pulse and stays at 1 until reset.
- R9: When `rst_i`=1 at an edge, `ev_count_o`, `phase_o`, `viol_o` and `err_o` are cleared, and the event inputs at that edge are ignored.
- R10: `phase_o` is 0 (collecting) while the count is below `THRESH`-1, 1 (armed: the next reference event is the threshold one) when it equals `THRESH`-1, and 2 (settled) when it equals `THRESH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all sampling on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset; observation starts after release |
| rel_mode_i | input | 1 | Relation select: 0 mirror, 1 one-shot |
| ref_ev_i | input | 1 | Reference event stream |
| der_ev_i | input | 1 | Derived event stream under check |
| viol_o | output | 1 | Registered one-cycle violation pulse |
| err_o | output | 1 | Sticky error flag |
| phase_o | output | 2 | Phase code: 0 collecting, 1 armed, 2 settled |
| ev_count_o | output | CNT_W | Saturating count of reference events |

## Verification
The bench targets the threshold sample itself in both directions. A design that is off by one in its count would either accept a silent derived stream on that sample or flag a correct one. It places a gap of thousands of idle cycles between reference events; a design with a hidden timeout or a wrapping gap counter would lose its place there. In one-shot mode it drives reference events with a quiet derived stream after the threshold, which a design that reused the mirror rule would wrongly flag. It also resets in the middle of a run to show that the sticky flag and the count clear while the inputs at the reset edge are ignored.

// File: rtl/evrel_pkg.sv
package evrel_pkg;

   typedef enum logic [1:0] {
      PH_COLLECT = 2'd0,
      PH_ARMED   = 2'd1,
      PH_SETTLED = 2'd2
   } phase_e;

   typedef enum logic {
      REL_MIRROR  = 1'b0,
      REL_ONESHOT = 1'b1
   } rel_e;

   // One bit per kind of breach; several may be set together.
   typedef struct packed {
      logic stray;     // derived without reference
      logic early;     // derived before the threshold event
      logic missed;    // threshold event without derived
      logic mismatch;  // mirror rule broken after threshold
      logic extra;     // one-shot rule broken after threshold
   } fault_s;

   localparam int unsigned FAULT_W = $bits(fault_s);

endpackage

// File: rtl/evrel_ordinal.sv
module evrel_ordinal
   import evrel_pkg::*;
#(
   parameter int unsigned THRESH = 5,
   parameter int unsigned CNT_W  = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             ev_i,
   output logic [CNT_W-1:0] count_o,
   output phase_e           phase_o
);

   localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(THRESH);
   localparam logic [CNT_W-1:0] CNT_ARMED = CNT_W'(THRESH - 1);
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

   logic [CNT_W-1:0] count_q;
   logic             at_top;

   assign at_top = (count_q == CNT_TOP);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         count_q <= '0;
      end else if (ev_i && !at_top) begin
         count_q <= count_q + CNT_ONE;
      end
   end

   assign count_o = count_q;

   // With a threshold of one there is no collecting phase at all.
   generate
      if (THRESH == 1) begin : g_phase_single
         always_comb begin
            phase_o = at_top ? PH_SETTLED : PH_ARMED;
         end
      end else begin : g_phase_multi
         always_comb begin
            if (at_top) begin
               phase_o = PH_SETTLED;
            end else if (count_q == CNT_ARMED) begin
               phase_o = PH_ARMED;
            end else begin
               phase_o = PH_COLLECT;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/evrel_classify.sv
module evrel_classify
   import evrel_pkg::*;
(
   input  logic   ref_i,
   input  logic   der_i,
   input  phase_e phase_i,
   input  rel_e   rel_i,
   output fault_s fault_o
);

   logic in_collect;
   logic in_armed;
   logic in_settled;

   assign in_collect = (phase_i == PH_COLLECT);
   assign in_armed   = (phase_i == PH_ARMED);
   assign in_settled = (phase_i == PH_SETTLED);

   always_comb begin
      fault_o          = '0;
      fault_o.stray    = der_i & ~ref_i;
      fault_o.early    = in_collect & der_i;
      fault_o.missed   = in_armed & ref_i & ~der_i;
      fault_o.mismatch = in_settled & (rel_i == REL_MIRROR) & (ref_i ^ der_i);
      fault_o.extra    = in_settled & (rel_i == REL_ONESHOT) & der_i;
   end

endmodule

// File: rtl/evrel_report.sv
module evrel_report
   import evrel_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_i,
   input  fault_s fault_i,
   output logic   viol_o,
   output logic   err_o
);

   logic any_fault;
   logic viol_q;
   logic err_q;

   assign any_fault = |fault_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         viol_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         viol_q <= any_fault;
         err_q  <= err_q | any_fault;
      end
   end

   assign viol_o = viol_q;
   assign err_o  = err_q;

endmodule

// File: rtl/evrel_monitor.sv
module evrel_monitor
   import evrel_pkg::*;
#(
   parameter int unsigned THRESH = 5,
   parameter int unsigned CNT_W  = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             rel_mode_i,
   input  logic             ref_ev_i,
   input  logic             der_ev_i,
   output logic             viol_o,
   output logic             err_o,
   output logic [1:0]       phase_o,
   output logic [CNT_W-1:0] ev_count_o
);

   generate
      if (THRESH < 1) begin : g_bad_thresh
         $error("evrel_monitor: THRESH must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_width
         $error("evrel_monitor: CNT_W must lie in 1..31");
      end else if ((THRESH >> CNT_W) != 0) begin : g_bad_fit
         $error("evrel_monitor: THRESH does not fit in CNT_W bits");
      end
   endgenerate

   phase_e phase_w;
   fault_s fault_w;
   rel_e   rel_w;

   assign rel_w = rel_e'(rel_mode_i);

   evrel_ordinal #(
      .THRESH (THRESH),
      .CNT_W  (CNT_W)
   ) u_ordinal (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .ev_i    (ref_ev_i),
      .count_o (ev_count_o),
      .phase_o (phase_w)
   );

   evrel_classify u_classify (
      .ref_i   (ref_ev_i),
      .der_i   (der_ev_i),
      .phase_i (phase_w),
      .rel_i   (rel_w),
      .fault_o (fault_w)
   );

   evrel_report u_report (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .fault_i (fault_w),
      .viol_o  (viol_o),
      .err_o   (err_o)
   );

   assign phase_o = phase_w;

endmodule

// File: rtl/evrel_monitor_chk.sv
module evrel_monitor_chk #(
   parameter int unsigned THRESH = 5,
   parameter int unsigned CNT_W  = 16
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             rel_mode_i,
   input logic             ref_ev_i,
   input logic             der_ev_i,
   input logic             viol_o,
   input logic             err_o,
   input logic [1:0]       phase_o,
   input logic [CNT_W-1:0] ev_count_o
);

   localparam logic [CNT_W-1:0] TOP = CNT_W'(THRESH);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assert_count_bounded_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      ev_count_o <= TOP);

   assert_count_idle_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      (!ref_ev_i) |=> $stable(ev_count_o));

   assert_count_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      (ref_ev_i && ev_count_o != TOP) |=> (ev_count_o == $past(ev_count_o) + ONE));

   assert_stray_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (der_ev_i && !ref_ev_i) |=> viol_o);

   assert_early_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_o == 2'd0 && der_ev_i) |=> viol_o);

   assert_missed_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_o == 2'd1 && ref_ev_i && !der_ev_i) |=> viol_o);

   assert_hit_clean_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_o == 2'd1 && ref_ev_i && der_ev_i) |=> (!viol_o && phase_o == 2'd2));

   assert_mirror_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_o == 2'd2 && !rel_mode_i && ref_ev_i != der_ev_i) |=> viol_o);

   assert_oneshot_quiet_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_o == 2'd2 && rel_mode_i && !der_ev_i) |=> !viol_o);

   assert_quiet_collect_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_o == 2'd0 && !der_ev_i) |=> !viol_o);

   assert_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      err_o |=> err_o);

   assert_pulse_sets_err_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      viol_o |-> err_o);

   assert_reset_clear_R9: assert property (@(posedge clk_i)
      rst_i |=> (!viol_o && !err_o && ev_count_o == '0));

   assert_phase_code_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      phase_o != 2'd3);

endmodule

bind evrel_monitor evrel_monitor_chk #(
   .THRESH (THRESH),
   .CNT_W  (CNT_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .rel_mode_i (rel_mode_i),
   .ref_ev_i   (ref_ev_i),
   .der_ev_i   (der_ev_i),
   .viol_o     (viol_o),
   .err_o      (err_o),
   .phase_o    (phase_o),
   .ev_count_o (ev_count_o)
);

// File: tb/evrel_monitor_tb_top.sv
`timescale 1ns/1ps
module evrel_monitor_tb_top;

   localparam int unsigned K     = 5;
   localparam int unsigned CW    = 16;
   localparam real         HALF  = 10.0;
   localparam int unsigned LIMIT = 200000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          mode = 1'b0;
   logic          a = 1'b0;
   logic          o = 1'b0;
   logic          viol;
   logic          err;
   logic [1:0]    phase;
   logic [CW-1:0] cnt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int exp_cnt = 0;
   bit exp_err = 1'b0;

   always #(HALF) clk = ~clk;

   evrel_monitor #(.THRESH(K), .CNT_W(CW)) dut_i (
      .clk_i      (clk),
      .rst_i      (rst),
      .rel_mode_i (mode),
      .ref_ev_i   (a),
      .der_ev_i   (o),
      .viol_o     (viol),
      .err_o      (err),
      .phase_o    (phase),
      .ev_count_o (cnt)
   );

   function automatic bit exp_bad(int c, bit m, bit ra, bit ro);
      if (ro && !ra) return 1'b1;
      if (c < int'(K) - 1) return ro;
      if (c == int'(K) - 1) return ra && !ro;
      if (!m) return ra != ro;
      return ro;
   endfunction

   function automatic string rule_tag(int c, bit m, bit ra, bit ro);
      if (ro && !ra) return "R2 R7";
      if (c < int'(K) - 1) return "R3 R7";
      if (c == int'(K) - 1) return "R4 R7";
      if (!m) return "R5 R7";
      return "R6 R7";
   endfunction

   function automatic int exp_phase(int c);
      if (c < int'(K) - 1) return 0;
      if (c == int'(K) - 1) return 1;
      return 2;
   endfunction

   function automatic bit legal_o(int c, bit m, bit ra);
      if (c < int'(K) - 1) return 1'b0;
      if (c == int'(K) - 1) return ra;
      return m ? 1'b0 : ra;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", fails, checks);
   endtask

   // One sampled cycle: drive at the falling edge, observe after the rising edge.
   task automatic step(bit ra, bit ro);
      bit bad;
      string tag;
      @(negedge clk);
      a = ra;
      o = ro;
      @(posedge clk);
      #1;
      bad = exp_bad(exp_cnt, mode, ra, ro);
      tag = rule_tag(exp_cnt, mode, ra, ro);
      chk(tag, int'(viol), int'(bad));
      exp_err = exp_err | bad;
      chk("R8", int'(err), int'(exp_err));
      if (ra && exp_cnt < int'(K)) exp_cnt++;
      chk("R1", int'(cnt), exp_cnt);
      chk("R10", int'(phase), exp_phase(exp_cnt));
   endtask

   // Quiet stretch: no checks per cycle, count must survive it.
   task automatic idle(int n);
      @(negedge clk);
      a = 1'b0;
      o = 1'b0;
      repeat (n) @(posedge clk);
   endtask

   task automatic do_reset(bit m);
      @(negedge clk);
      rst  = 1'b1;
      mode = m;
      a    = 1'b1;
      o    = 1'b1;
      @(posedge clk);
      #1;
      chk("R9", int'(viol), 0);
      chk("R9", int'(err), 0);
      chk("R9", int'(cnt), 0);
      chk("R9", int'(phase), exp_phase(0));
      @(negedge clk);
      rst = 1'b0;
      a   = 1'b0;
      o   = 1'b0;
      exp_cnt = 0;
      exp_err = 1'b0;
   endtask

   initial begin : watchdog
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL R7 watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin : stim
      int seed;
      seed = $urandom(32'd20240611);

      // Reset state, with active-looking inputs held during reset.
      do_reset(1'b0);

      // Mirror: clean run across gaps, then mismatches and a stray.
      for (int i = 0; i < int'(K) - 1; i++) begin
         step(1'b1, 1'b0);
         step(1'b0, 1'b0);
      end
      step(1'b1, 1'b1);          // threshold hit, clean (R4)
      step(1'b1, 1'b1);
      step(1'b0, 1'b0);
      chk("R8", int'(err), 0);
      step(1'b1, 1'b0);          // mirror mismatch (R5)
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);          // stray derived event (R2)
      step(1'b0, 1'b0);
      chk("R8", int'(err), 1);

      // Threshold event with silent derived stream (R4), then sticky error.
      do_reset(1'b0);
      for (int i = 0; i < int'(K) - 1; i++) step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1);

      // One-shot: early derived event (R3).
      do_reset(1'b1);
      step(1'b1, 1'b1);
      step(1'b0, 1'b0);

      // One-shot clean fire, later reference events with quiet derived (R6).
      do_reset(1'b1);
      for (int i = 0; i < int'(K) - 1; i++) step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      chk("R6", int'(err), 0);
      step(1'b1, 1'b1);          // second fire (R6)
      step(1'b0, 1'b0);

      // Long idle gaps between reference events (R1).
      do_reset(1'b0);
      step(1'b1, 1'b0);
      idle(3000);
      chk("R1", int'(cnt), 1);
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      idle(2500);
      for (int i = 2; i < int'(K) - 1; i++) step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      step(1'b0, 1'b0);
      chk("R1", int'(cnt), int'(K));

      // Reset in mid-run after an error (R9).
      step(1'b0, 1'b1);
      do_reset(1'b0);
      step(1'b0, 1'b0);

      // Constrained random runs with occasional corruption.
      for (int run = 0; run < 40; run++) begin
         do_reset(1'($urandom_range(0, 1)));
         for (int cyc = 0; cyc < 150; cyc++) begin
            bit ra;
            bit ro;
            ra = ($urandom_range(0, 9) < 4);
            ro = legal_o(exp_cnt, mode, ra);
            if ($urandom_range(0, 15) == 0) ro = ~ro;
            step(ra, ro);
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule